// File: doc/BRIEF.md
# Banked Strided and Gather/Scatter Vector Memory

This block holds a word-addressed memory that is divided into a configurable number of banks, and it serves one vector load or store operation at a time. An operation is launched with a one-cycle start pulse. The pulse carries four values: an addressing mode, a base address, a stride and an element count. The address generator works out one element address per clock. The bank is the remainder of that address divided by the bank count, which may be any integer of two or more, including a prime. The row inside the bank is the quotient.

Each bank is busy for a fixed access latency after it accepts an access. The element at the head of the stream waits while its bank is busy, and no later element may pass it. The caller keeps the current element's index offset and its store data on two inputs. A take strobe tells the caller that the element has been consumed, so the next one is wanted on the following clock.

Load results return with a valid strobe, in element order. A single done pulse marks the end of every operation.

Top module: `vmem_banked`

## Requirements
- R1: The mode code selects the addressing. 0 is unit stride, where element k is at base+k. 1 is constant stride, where element k is at base+k*stride. 2 is indexed, where element k is at base plus the index offset presented with element k. 3 behaves as 0. All address sums wrap modulo 2^ADDR_W.
- R2: A word address A is held in bank A mod NBANKS, at row A div NBANKS, so consecutive addresses fall in consecutive banks. Data stored at an address is read back from the same address.
- R3: At most one element is issued per clock, and elements issue in element order. `el_take` is high in exactly the cycles in which the presented element is consumed, once per element.
- R4: A bank that accepted an access at clock edge t accepts no other access before edge t+LAT. An element aimed at a busy bank holds the whole stream until that bank is free.
- R5: Load data for an element issued at edge t appears with `rd_valid` in the cycle after edge t+LAT-1. For an unconflicted stream started at edge s, the first element is therefore valid after edge s+LAT, and one element follows per clock after that.
- R6: Load results are returned in element order, one result per element and no extra results.
- R7: `op_done` is a one-cycle pulse in the cycle after the return slot of the last element, which is LAT edges after that element issued. This holds for both loads and stores.
- R8: A store writes `el_wdata` to its element address and produces no `rd_valid`. When elements of a store share an address, the later element wins.
- R9: A stride of zero is legal. Every element then goes to the same bank, and elements issue LAT clocks apart.
- R10: A start pulse is ignored while an operation is still issuing, and also when the element count is zero.
- R11: While reset is held, `rd_valid`, `op_done` and `el_take` are low.
- R12: With NBANKS=5, a constant stride that is coprime to 5 runs at one element per clock. A stride that is a multiple of 5 returns to a single bank and issues one element per LAT clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_start | input | 1 | Launch pulse for a new operation |
| op_mode | input | 2 | Addressing mode code (see R1) |
| op_store | input | 1 | 1 for store, 0 for load |
| op_base | input | ADDR_W | Base word address |
| op_stride | input | ADDR_W | Element stride, used in mode 1 |
| op_len | input | VL_W | Element count, from 1 to MAX_VL |
| el_index | input | ADDR_W | Index offset of the current element, used in mode 2 |
| el_wdata | input | DATA_W | Store data of the current element |
| el_take | output | 1 | The current element is consumed at the coming edge |
| rd_valid | output | 1 | Load result valid |
| rd_data | output | DATA_W | Load result |
| op_done | output | 1 | End-of-operation pulse |

## Verification
The assertions assume that the caller changes `el_index` and `el_wdata` only after a cycle in which `el_take` was high. They also assume that the caller does not expect a start to be accepted while an operation is still issuing, and that element counts never exceed MAX_VL. The stimulus meets these assumptions by design. It advances its element pointer only on an observed take, it sends a stray start only on purpose to check R10, and it keeps every count at or below 64.

Expected return cycles come from an independent model of per-bank free times. That model is applied to unit-stride streams, coprime strides, bank-multiple strides, a zero stride, wrapping strides, and gathers that repeat and collide on banks.

// File: rtl/vmem_pkg.sv
package vmem_pkg;
  typedef enum logic [1:0] {
    MODE_UNIT   = 2'd0,
    MODE_STRIDE = 2'd1,
    MODE_INDEX  = 2'd2,
    MODE_ALT    = 2'd3
  } vmode_e;
endpackage

// File: rtl/vmem_agen.sv
module vmem_agen
  import vmem_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int VL_W   = 7,
  parameter int NBANKS = 5,
  parameter int BANK_W = 3,
  parameter int ROW_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_start,
  input  logic [1:0]        op_mode,
  input  logic              op_store,
  input  logic [ADDR_W-1:0] op_base,
  input  logic [ADDR_W-1:0] op_stride,
  input  logic [VL_W-1:0]   op_len,
  input  logic [ADDR_W-1:0] el_index,
  input  logic              issue_fire,
  output logic              issue_req,
  output logic              req_store,
  output logic              req_last,
  output logic [BANK_W-1:0] req_bank,
  output logic [ROW_W-1:0]  req_row
);
  localparam logic [ADDR_W-1:0] NB_A = ADDR_W'(NBANKS);

  logic              active_q, active_d;
  logic              index_q, index_d;
  logic              store_q, store_d;
  logic [VL_W-1:0]   cnt_q, cnt_d;
  logic [VL_W-1:0]   len_q, len_d;
  logic [ADDR_W-1:0] acc_q, acc_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic [ADDR_W-1:0] step_q, step_d;
  logic              accept;
  logic [ADDR_W-1:0] el_addr;

  assign accept = op_start && !active_q && (op_len != '0);

  always_comb begin
    active_d = active_q;
    index_d  = index_q;
    store_d  = store_q;
    cnt_d    = cnt_q;
    len_d    = len_q;
    acc_d    = acc_q;
    base_d   = base_q;
    step_d   = step_q;
    if (accept) begin
      active_d = 1'b1;
      index_d  = (op_mode == MODE_INDEX);
      store_d  = op_store;
      cnt_d    = '0;
      len_d    = op_len;
      acc_d    = op_base;
      base_d   = op_base;
      step_d   = (op_mode == MODE_STRIDE) ? op_stride : ADDR_W'(1);
    end else if (issue_fire) begin
      cnt_d = cnt_q + VL_W'(1);
      acc_d = acc_q + step_q;
      if (req_last) active_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      index_q  <= 1'b0;
      store_q  <= 1'b0;
      cnt_q    <= '0;
      len_q    <= '0;
      acc_q    <= '0;
      base_q   <= '0;
      step_q   <= '0;
    end else begin
      active_q <= active_d;
      index_q  <= index_d;
      store_q  <= store_d;
      cnt_q    <= cnt_d;
      len_q    <= len_d;
      acc_q    <= acc_d;
      base_q   <= base_d;
      step_q   <= step_d;
    end
  end

  assign el_addr   = index_q ? (base_q + el_index) : acc_q;
  assign issue_req = active_q;
  assign req_store = store_q;
  assign req_last  = (cnt_q == len_q - VL_W'(1));
  assign req_bank  = BANK_W'(el_addr % NB_A);
  assign req_row   = ROW_W'(el_addr / NB_A);

  AST_FIRE_WHILE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    issue_fire |-> active_q); // R3
  AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (cnt_q < len_q)); // R6
  AST_START_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (op_start && active_q) |=> ($stable(len_q) && $stable(base_q))); // R10
endmodule

// File: rtl/vmem_bank.sv
module vmem_bank #(
  parameter int DATA_W = 16,
  parameter int ROW_W  = 6,
  parameter int ROWS   = 52,
  parameter int LAT    = 4,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              we,
  input  logic [ROW_W-1:0]  row,
  input  logic [DATA_W-1:0] wdata,
  output logic              busy,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [ROWS];
  logic [CNT_W-1:0]  cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (sel)               cnt_d = CNT_W'(LAT - 1);
    else if (cnt_q != '0)  cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_ff @(posedge clk) begin
    if (sel && we) mem[row] <= wdata;
  end

  assign busy  = (cnt_q != '0);
  assign rdata = mem[row];

  AST_SEL_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    sel |-> !busy); // R4
  AST_BUSY_AFTER_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    ((LAT > 1) && sel) |=> busy); // R4
endmodule

// File: rtl/vmem_retpipe.sv
module vmem_retpipe #(
  parameter int DATA_W = 16,
  parameter int LAT    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_v,
  input  logic              in_rd,
  input  logic              in_last,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_rd_v,
  output logic [DATA_W-1:0] out_data,
  output logic              done
);
  logic [LAT-1:0]    v_q, v_d;
  logic [LAT-1:0]    rd_q, rd_d;
  logic [LAT-1:0]    last_q, last_d;
  logic [DATA_W-1:0] data_q [LAT];
  logic              done_q, done_d;

  always_comb begin
    v_d[0]    = in_v;
    rd_d[0]   = in_rd;
    last_d[0] = in_last;
    for (int s = 1; s < LAT; s++) begin
      v_d[s]    = v_q[s-1];
      rd_d[s]   = rd_q[s-1];
      last_d[s] = last_q[s-1];
    end
    done_d = v_q[LAT-1] && last_q[LAT-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q    <= '0;
      rd_q   <= '0;
      last_q <= '0;
      done_q <= 1'b0;
    end else begin
      v_q    <= v_d;
      rd_q   <= rd_d;
      last_q <= last_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk) begin
    if (in_v) data_q[0] <= in_data;
  end

  for (genvar s = 1; s < LAT; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (v_q[s-1]) data_q[s] <= data_q[s-1];
    end
  end

  assign out_rd_v = v_q[LAT-1] && rd_q[LAT-1];
  assign out_data = data_q[LAT-1];
  assign done     = done_q;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_DONE_FOLLOWS_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(v_q[LAT-1])); // R7
endmodule

// File: rtl/vmem_banked.sv
module vmem_banked #(
  parameter int NBANKS = 5,
  parameter int LAT    = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int MAX_VL = 64,
  localparam int VL_W  = $clog2(MAX_VL + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_start,
  input  logic [1:0]        op_mode,
  input  logic              op_store,
  input  logic [ADDR_W-1:0] op_base,
  input  logic [ADDR_W-1:0] op_stride,
  input  logic [VL_W-1:0]   op_len,
  input  logic [ADDR_W-1:0] el_index,
  input  logic [DATA_W-1:0] el_wdata,
  output logic              el_take,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              op_done
);
  localparam int BANK_W = (NBANKS > 1) ? $clog2(NBANKS) : 1;
  localparam int ROWS   = ((2 ** ADDR_W) + NBANKS - 1) / NBANKS;
  localparam int ROW_W  = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int CNT_W  = $clog2(LAT + 1);

  logic              rst_meta_q, rst_sync_q;
  logic              issue_req, issue_fire, req_store, req_last;
  logic [BANK_W-1:0] req_bank;
  logic [ROW_W-1:0]  req_row;
  logic [NBANKS-1:0] bank_busy, bank_sel;
  logic [DATA_W-1:0] bank_rdata [NBANKS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  vmem_agen #(
    .ADDR_W(ADDR_W), .VL_W(VL_W), .NBANKS(NBANKS), .BANK_W(BANK_W), .ROW_W(ROW_W)
  ) u_agen (
    .clk(clk), .rst_n(rst_sync_q),
    .op_start(op_start), .op_mode(op_mode), .op_store(op_store),
    .op_base(op_base), .op_stride(op_stride), .op_len(op_len),
    .el_index(el_index), .issue_fire(issue_fire),
    .issue_req(issue_req), .req_store(req_store), .req_last(req_last),
    .req_bank(req_bank), .req_row(req_row)
  );

  assign issue_fire = issue_req && !bank_busy[req_bank];
  assign el_take    = issue_fire;

  for (genvar g = 0; g < NBANKS; g++) begin : g_bank
    assign bank_sel[g] = issue_fire && (req_bank == BANK_W'(g));
    vmem_bank #(
      .DATA_W(DATA_W), .ROW_W(ROW_W), .ROWS(ROWS), .LAT(LAT), .CNT_W(CNT_W)
    ) u_bank (
      .clk(clk), .rst_n(rst_sync_q),
      .sel(bank_sel[g]), .we(req_store), .row(req_row), .wdata(el_wdata),
      .busy(bank_busy[g]), .rdata(bank_rdata[g])
    );
  end

  vmem_retpipe #(.DATA_W(DATA_W), .LAT(LAT)) u_ret (
    .clk(clk), .rst_n(rst_sync_q),
    .in_v(issue_fire), .in_rd(!req_store), .in_last(req_last),
    .in_data(bank_rdata[req_bank]),
    .out_rd_v(rd_valid), .out_data(rd_data), .done(op_done)
  );

  AST_ONE_BANK_PER_CYCLE: assert property (@(posedge clk) disable iff (!rst_sync_q)
    $onehot0(bank_sel)); // R3
  AST_TAKE_HITS_BANK: assert property (@(posedge clk) disable iff (!rst_sync_q)
    el_take |-> ($countones(bank_sel) == 1)); // R3
endmodule

// File: tb/vmem_banked_bench.sv
module vmem_banked_bench;
  localparam int NB = 5, LT = 4, AW = 8, DW = 16, MVL = 64, VW = 7;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n, op_start, op_store;
  logic [1:0]    op_mode;
  logic [AW-1:0] op_base, op_stride, el_index;
  logic [VW-1:0] op_len;
  logic [DW-1:0] el_wdata;
  logic          el_take, rd_valid, op_done;
  logic [DW-1:0] rd_data;

  vmem_banked #(.NBANKS(NB), .LAT(LT), .ADDR_W(AW), .DATA_W(DW), .MAX_VL(MVL)) u_vmem_banked (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_mode(op_mode), .op_store(op_store),
    .op_base(op_base), .op_stride(op_stride), .op_len(op_len), .el_index(el_index),
    .el_wdata(el_wdata), .el_take(el_take), .rd_valid(rd_valid), .rd_data(rd_data),
    .op_done(op_done)
  );

  typedef struct { logic [DW-1:0] d; int c; string tag; } exp_t;
  exp_t q[$];

  int cyc = 0;
  int checks = 0, errors = 0;
  int rd_seen = 0, done_seen = 0;
  int exp_done_c = -1;
  string done_tag = "R7";
  logic [DW-1:0] refm [256];
  logic [AW-1:0] idxv [MVL];
  logic [DW-1:0] wdv [MVL];

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: cycle %0d expected below 150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (rd_valid) begin
        rd_seen = rd_seen + 1;
        checks = checks + 1;
        if (q.size() == 0) begin
          errors = errors + 1;
          $display("FAIL R6/R8: unexpected result %h at cycle %0d, expected none", rd_data, cyc);
        end else begin
          exp_t e;
          e = q.pop_front();
          if (rd_data !== e.d || cyc != e.c) begin
            errors = errors + 1;
            $display("FAIL %s: data %h cycle %0d, expected data %h cycle %0d",
                     e.tag, rd_data, cyc, e.d, e.c);
          end
        end
      end
      if (op_done) begin
        done_seen = done_seen + 1;
        checks = checks + 1;
        if (cyc != exp_done_c) begin
          errors = errors + 1;
          $display("FAIL %s: done at cycle %0d, expected %0d", done_tag, cyc, exp_done_c);
        end
      end
    end
  end

  task automatic check(input bit ok, input string msg, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0d expected %0d", msg, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] m, input bit st, input logic [AW-1:0] b,
                        input logic [AW-1:0] s_, input int n, input bit poke, input string tag);
    int sc, prev, t, bk, k, j, takes, d0, r0, guard;
    int free_c [NB];
    logic [AW-1:0] a;
    for (int i = 0; i < NB; i++) free_c[i] = 0;
    @(negedge clk);
    op_start = 1'b1; op_mode = m; op_store = st; op_base = b; op_stride = s_;
    op_len = VW'(n);
    el_index = idxv[0]; el_wdata = wdv[0];
    sc = cyc + 1;
    prev = sc;
    for (int e = 0; e < n; e++) begin
      if (m == 2'd2)      a = b + idxv[e];
      else if (m == 2'd1) a = b + AW'(e * int'(s_));
      else                a = b + AW'(e);
      bk = int'(a) % NB;
      t = (prev + 1 > free_c[bk]) ? prev + 1 : free_c[bk];
      free_c[bk] = t + LT;
      prev = t;
      if (st) refm[a] = wdv[e];
      else q.push_back('{d: refm[a], c: t + LT - 1, tag: tag});
    end
    exp_done_c = prev + LT;
    done_tag = {tag, "/R7"};
    d0 = done_seen; r0 = rd_seen;
    @(negedge clk);
    op_start = 1'b0;
    k = 0; j = 0; takes = 0;
    while (k < n && j < 5000) begin
      el_index = idxv[k]; el_wdata = wdv[k];
      if (poke && j == 2) begin
        op_start = 1'b1; op_len = VW'(5); op_base = 8'h77; op_mode = 2'd0; op_store = 1'b1;
      end else op_start = 1'b0;
      #1;
      if (el_take) begin k++; takes++; end
      @(negedge clk);
      j++;
    end
    op_start = 1'b0;
    guard = 0;
    while (done_seen == d0 && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    repeat (3) @(negedge clk);
    check(takes == n, {tag, "/R3 take count"}, takes, n);
    check(done_seen == d0 + 1, {tag, "/R7 done count"}, done_seen - d0, 1);
    if (st) check(rd_seen == r0, "R8 no results for a store", rd_seen - r0, 0);
    check(q.size() == 0, {tag, "/R6 results outstanding"}, q.size(), 0);
    q.delete();
  endtask

  task automatic fill_wdata(input int seed);
    for (int i = 0; i < MVL; i++) wdv[i] = DW'(seed + i * 37);
  endtask

  initial begin
    rst_n = 1'b0; op_start = 1'b0; op_mode = 2'd0; op_store = 1'b0;
    op_base = '0; op_stride = '0; op_len = '0; el_index = '0; el_wdata = '0;
    for (int i = 0; i < MVL; i++) idxv[i] = '0;
    repeat (3) @(negedge clk);
    check(!rd_valid && !op_done && !el_take, "R11 outputs low in reset",
          int'(rd_valid) + int'(op_done) + int'(el_take), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 R2 R8: fill addresses 0..191 with unit-stride stores of full length
    fill_wdata(16'hA000); run_op(2'd0, 1'b1, 8'd0,   8'd0, 64, 1'b0, "R8");
    fill_wdata(16'hB100); run_op(2'd0, 1'b1, 8'd64,  8'd0, 64, 1'b0, "R8");
    fill_wdata(16'hC200); run_op(2'd0, 1'b1, 8'd128, 8'd0, 64, 1'b0, "R8");
    // R5 R2: unconflicted unit-stride load at full length
    run_op(2'd0, 1'b0, 8'd0, 8'd0, 64, 1'b0, "R5");
    // R12: coprime strides store and load at full rate
    fill_wdata(16'h5000); run_op(2'd1, 1'b1, 8'd100, 8'd2, 20, 1'b0, "R12");
    run_op(2'd1, 1'b0, 8'd64, 8'd3, 24, 1'b0, "R12");
    // R4 R12: stride equal to bank count returns to one bank
    run_op(2'd1, 1'b0, 8'd0, 8'd5, 8, 1'b0, "R4");
    // R9: zero stride
    run_op(2'd1, 1'b0, 8'd17, 8'd0, 6, 1'b0, "R9");
    // R1: indexed scatter then gather with repeats and bank collisions
    for (int i = 0; i < 16; i++) idxv[i] = AW'((i * 13) % 50);
    fill_wdata(16'h7700); run_op(2'd2, 1'b1, 8'd30, 8'd0, 16, 1'b0, "R1");
    for (int i = 0; i < 20; i++) idxv[i] = AW'((i * 7) % 20);
    run_op(2'd2, 1'b0, 8'd30, 8'd0, 20, 1'b0, "R1");
    for (int i = 0; i < 8; i++) idxv[i] = AW'((i % 3) * 5);
    run_op(2'd2, 1'b0, 8'd30, 8'd0, 8, 1'b0, "R4");
    // R1: reserved mode code acts as unit stride
    run_op(2'd3, 1'b0, 8'd10, 8'd0, 10, 1'b0, "R1");
    // R1: stride wraps around the address space
    fill_wdata(16'h3300); run_op(2'd1, 1'b1, 8'd250, 8'd3, 10, 1'b0, "R1");
    run_op(2'd1, 1'b0, 8'd250, 8'd3, 10, 1'b0, "R1");
    // R10: stray start while an operation is issuing
    run_op(2'd0, 1'b0, 8'd5, 8'd0, 12, 1'b1, "R10");
    run_op(2'd0, 1'b0, 8'd119, 8'd0, 5, 1'b0, "R10");
    // R10: zero length start is ignored
    begin
      int r0, d0, tk;
      r0 = rd_seen; d0 = done_seen; tk = 0;
      @(negedge clk);
      op_start = 1'b1; op_len = '0; op_mode = 2'd0; op_store = 1'b0; op_base = 8'd3;
      @(negedge clk);
      op_start = 1'b0;
      for (int i = 0; i < 12; i++) begin
        #1; if (el_take) tk++;
        @(negedge clk);
      end
      check(rd_seen == r0 && done_seen == d0 && tk == 0, "R10 zero length ignored",
            (rd_seen - r0) + (done_seen - d0) + tk, 0);
    end
    run_op(2'd0, 1'b0, 8'd140, 8'd0, 4, 1'b0, "R5");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule